// File: doc/BRIEF.md
# Floating-Point Compare Unit

This block compares two 64-bit IEEE-754 double-precision operands and produces a one-hot 4-bit condition code. The code says less-than, greater-than, equal or unordered. One input picks between two variants: an ordered compare and an unordered compare. They differ only in which invalid-operation flags a NaN operand raises. In the ordered variant, the result also depends on an invalid-exception enable input.

A single-cycle `start` pulse captures the operands and the control inputs. One clock later the block updates three things. It merges the code into the low four bits of a 5-bit result-flags register and keeps the top bit of that register. It writes the code into one selected 4-bit field of a 32-bit condition register made of eight fields. It ORs any raised exception into sticky flags. A surrounding pipeline gives the operands, the variant and the destination field index, and it reads the registered state back on the outputs.

Top module: `fcmp_unit`

## Requirements
- R1: After reset, `done` is 0, `code` is 0000, `cr` is 32'h0000_0000, `fprf` is 5'b10000 and `vx_snan`, `vx_cmp`, `fx` are 0.
- R2: `done` is 1 in exactly the cycle that follows a cycle with `start` high, and it is 0 in every other cycle.
- R3: The code is 1000 when A is less than B, 0100 when A is greater, 0010 when they are equal and 0001 (unordered) when either operand is a NaN. A NaN has an all-ones exponent (bits 62:52) and a nonzero fraction (bits 51:0).
- R4: +0 and -0 compare equal. Sign, infinities and subnormals order as real numbers: every negative value is less than every positive value, and -inf is below every finite value.
- R5: A NaN is signaling when fraction bit 51 is 0. A signaling NaN in either operand sets `vx_snan` in both variants.
- R6: In the ordered variant (`ordered`=1), quiet NaN operands with no signaling NaN set `vx_cmp`. In the unordered variant, quiet NaNs leave all exception flags unchanged.
- R7: In the ordered variant with a signaling NaN, `vx_cmp` is set only when `inv_en` is 0.
- R8: `vx_snan` and `vx_cmp` are sticky until reset. `fx` is set together with any flag that a compare raises, and it is also sticky.
- R9: A compare replaces `fprf[3:0]` with the code and leaves `fprf[4]` unchanged.
- R10: A compare writes the code into field k = `field_sel` of `cr`, at bits [31-4k : 28-4k]. All other fields keep their values.
- R11: In a cycle without `start`, `cr`, `fprf`, `code` and the exception flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that launches one compare |
| ordered | input | 1 | 1 = ordered variant, 0 = unordered variant |
| inv_en | input | 1 | Invalid-operation exception enable |
| field_sel | input | 3 | Destination field index in `cr` |
| op_a | input | 64 | Operand A (IEEE-754 double) |
| op_b | input | 64 | Operand B (IEEE-754 double) |
| done | output | 1 | Result valid, one cycle after `start` |
| code | output | 4 | Last condition code (LT,GT,EQ,UN from MSB) |
| fprf | output | 5 | Result-flags register |
| cr | output | 32 | Condition register of eight 4-bit fields |
| vx_snan | output | 1 | Sticky signaling-NaN invalid flag |
| vx_cmp | output | 1 | Sticky invalid-compare flag |
| fx | output | 1 | Sticky exception summary |

## Verification
The hardest situation to reach is a quiet NaN that leaves the flags untouched, and a signaling NaN under ordered compare with the enable set. The flags are sticky, so once any earlier compare has set them, neither case can be seen at the ports. The stimulus orders these cases first after a reset: unordered quiet NaN, unordered signaling NaN, ordered signaling NaN with the enable set, and only then ordered quiet NaN. A second reset isolates the ordered signaling NaN with the enable cleared. The scoreboard keeps its own copy of every register, so writes to one field are also checked against the seven fields around it.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  // operand classification
  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic is_zero;
    logic sign;
  } fp_class_t;

  // one-hot condition codes
  localparam logic [3:0] CC_LT = 4'b1000;
  localparam logic [3:0] CC_GT = 4'b0100;
  localparam logic [3:0] CC_EQ = 4'b0010;
  localparam logic [3:0] CC_UN = 4'b0001;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] op,
  output fp_class_t             cls
);
  localparam int MSB = EXP_W + FRAC_W;

  function automatic fp_class_t classify(input logic [EXP_W+FRAC_W:0] v);
    fp_class_t c;
    logic exp_ones;
    logic frac_nz;
    exp_ones  = &v[MSB-1:FRAC_W];
    frac_nz   = |v[FRAC_W-1:0];
    c.sign    = v[MSB];
    c.is_nan  = exp_ones && frac_nz;
    c.is_snan = exp_ones && frac_nz && !v[FRAC_W-1];
    c.is_zero = ~|v[MSB-1:0];
    return c;
  endfunction

  always_comb cls = classify(op);
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  fp_class_t     a_cls,
  input  fp_class_t     b_cls,
  output logic [3:0]    cc
);
  // ordering of two non-NaN values in sign-magnitude form
  function automatic logic [3:0] order(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                       input logic both_zero);
    logic [DW-2:0] mx, my;
    mx = x[DW-2:0];
    my = y[DW-2:0];
    if (both_zero || x == y) return CC_EQ;
    if (x[DW-1] != y[DW-1]) return x[DW-1] ? CC_LT : CC_GT;
    if (!x[DW-1]) return (mx < my) ? CC_LT : CC_GT;
    return (mx > my) ? CC_LT : CC_GT;
  endfunction

  always_comb begin
    if (a_cls.is_nan || b_cls.is_nan) cc = CC_UN;
    else                              cc = order(a, b, a_cls.is_zero && b_cls.is_zero);
  end
endmodule

// File: rtl/fcmp_excpt.sv
module fcmp_excpt
  import fcmp_pkg::*;
(
  input  fp_class_t a_cls,
  input  fp_class_t b_cls,
  input  logic      ordered,
  input  logic      inv_en,
  output logic      raise_snan,
  output logic      raise_cmp
);
  logic any_nan, any_snan;
  always_comb begin
    any_nan    = a_cls.is_nan || b_cls.is_nan;
    any_snan   = a_cls.is_snan || b_cls.is_snan;
    raise_snan = any_snan;
    if (!ordered)      raise_cmp = 1'b0;
    else if (any_snan) raise_cmp = !inv_en;
    else               raise_cmp = any_nan;
  end
endmodule

// File: rtl/fcmp_regs.sv
module fcmp_regs #(
  parameter int          FIELDS    = 8,
  parameter int          CC_W      = 4,
  parameter logic [4:0]  FPRF_INIT = 5'b10000,
  localparam int         SEL_W     = $clog2(FIELDS),
  localparam int         CR_W      = FIELDS * CC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SEL_W-1:0]  sel,
  input  logic [CC_W-1:0]   cc_in,
  input  logic              raise_snan,
  input  logic              raise_cmp,
  output logic              done,
  output logic [CC_W-1:0]   code,
  output logic [CC_W:0]     fprf,
  output logic [CR_W-1:0]   cr,
  output logic              vx_snan,
  output logic              vx_cmp,
  output logic              fx
);
  logic [CC_W-1:0] fld_q [FIELDS];

  // one register per field; field 0 is the most significant nibble
  for (genvar k = 0; k < FIELDS; k++) begin : g_fld
    always_ff @(posedge clk) begin
      if (!rst_n)                                     fld_q[k] <= '0;
      else if (start && sel == SEL_W'(k))             fld_q[k] <= cc_in;
    end
    assign cr[CC_W*(FIELDS-1-k) +: CC_W] = fld_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done    <= 1'b0;
      code    <= '0;
      fprf    <= FPRF_INIT;
      vx_snan <= 1'b0;
      vx_cmp  <= 1'b0;
      fx      <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        code         <= cc_in;
        fprf[CC_W-1:0] <= cc_in;
        vx_snan      <= vx_snan | raise_snan;
        vx_cmp       <= vx_cmp | raise_cmp;
        fx           <= fx | raise_snan | raise_cmp;
      end
    end
  end

  p_done_r2:   assert property (@(posedge clk) disable iff (!rst_n) start |=> done);
  p_nodone_r2: assert property (@(posedge clk) disable iff (!rst_n) !start |=> !done);
  p_snan_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n) vx_snan |=> vx_snan);
  p_cmp_sticky_r8:  assert property (@(posedge clk) disable iff (!rst_n) vx_cmp |=> vx_cmp);
  p_fx_sum_r8: assert property (@(posedge clk) disable iff (!rst_n) (vx_snan || vx_cmp) |-> fx);
  p_keep_top_r9: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> $stable(fprf[CC_W]));
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(cr) && $stable(fprf) && $stable(code) && $stable(vx_snan) && $stable(vx_cmp)));
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int         EXP_W     = 11,
  parameter int         FRAC_W    = 52,
  parameter int         FIELDS    = 8,
  parameter logic [4:0] FPRF_INIT = 5'b10000,
  localparam int        DW        = EXP_W + FRAC_W + 1,
  localparam int        SEL_W     = $clog2(FIELDS),
  localparam int        CR_W      = FIELDS * 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ordered,
  input  logic             inv_en,
  input  logic [SEL_W-1:0] field_sel,
  input  logic [DW-1:0]    op_a,
  input  logic [DW-1:0]    op_b,
  output logic             done,
  output logic [3:0]       code,
  output logic [4:0]       fprf,
  output logic [CR_W-1:0]  cr,
  output logic             vx_snan,
  output logic             vx_cmp,
  output logic             fx
);
  fp_class_t  cls_ab [2];
  logic [3:0] cc_w;
  logic       raise_snan_w, raise_cmp_w;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op  (i == 0 ? op_a : op_b),
      .cls (cls_ab[i])
    );
  end

  fcmp_order #(.DW(DW)) u_order (
    .a(op_a), .b(op_b), .a_cls(cls_ab[0]), .b_cls(cls_ab[1]), .cc(cc_w)
  );

  fcmp_excpt u_excpt (
    .a_cls(cls_ab[0]), .b_cls(cls_ab[1]), .ordered(ordered), .inv_en(inv_en),
    .raise_snan(raise_snan_w), .raise_cmp(raise_cmp_w)
  );

  fcmp_regs #(.FIELDS(FIELDS), .CC_W(4), .FPRF_INIT(FPRF_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .start(start), .sel(field_sel), .cc_in(cc_w),
    .raise_snan(raise_snan_w), .raise_cmp(raise_cmp_w),
    .done(done), .code(code), .fprf(fprf), .cr(cr),
    .vx_snan(vx_snan), .vx_cmp(vx_cmp), .fx(fx)
  );

  // named events for the properties
  logic nan_seen, snan_seen, zeros_seen;
  assign nan_seen   = cls_ab[0].is_nan  || cls_ab[1].is_nan;
  assign snan_seen  = cls_ab[0].is_snan || cls_ab[1].is_snan;
  assign zeros_seen = cls_ab[0].is_zero && cls_ab[1].is_zero && !nan_seen;

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n) done |-> $countones(code) == 1);
  p_nan_un_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && nan_seen) |=> code == CC_UN);
  p_zero_eq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && zeros_seen) |=> code == CC_EQ);
  p_snan_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && snan_seen) |=> vx_snan);
  p_unord_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ordered && !snan_seen) |=> ($stable(vx_snan) && $stable(vx_cmp) && $stable(fx)));
  p_ord_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ordered && nan_seen && !snan_seen) |=> vx_cmp);
  p_ord_snan_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ordered && snan_seen && inv_en) |=> $stable(vx_cmp));
  p_fprf_code_r9: assert property (@(posedge clk) disable iff (!rst_n) done |-> fprf[3:0] == code);
endmodule

// File: tb/sim_fcmp_unit.sv
`timescale 1ns/1ps
module sim_fcmp_unit;
  typedef struct {
    logic [3:0]  code;
    logic [4:0]  fprf;
    logic [31:0] cr;
    logic        snan, cmp, fx;
    string       tag;
  } exp_t;

  logic        clk = 0, rst_n = 0, start = 0, ordered = 0, inv_en = 0;
  logic [2:0]  field_sel = 0;
  logic [63:0] op_a = 0, op_b = 0;
  logic        done, vx_snan, vx_cmp, fx;
  logic [3:0]  code;
  logic [4:0]  fprf;
  logic [31:0] cr;

  int checks = 0, errors = 0;
  exp_t q[$];
  // bench copy of the architectural state
  logic [31:0] m_cr;
  logic [4:0]  m_fprf;
  logic [3:0]  m_code;
  logic        m_snan, m_cmp, m_fx;

  always #5 clk = ~clk;

  fcmp_unit u0 (.clk(clk), .rst_n(rst_n), .start(start), .ordered(ordered), .inv_en(inv_en),
    .field_sel(field_sel), .op_a(op_a), .op_b(op_b), .done(done), .code(code), .fprf(fprf),
    .cr(cr), .vx_snan(vx_snan), .vx_cmp(vx_cmp), .fx(fx));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cr = 32'h0; m_fprf = 5'b10000; m_code = 4'b0; m_snan = 0; m_cmp = 0; m_fx = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; start = 0;
    repeat (2) @(negedge clk);
    model_reset();
    chk("R1 done", done, 0);
    chk("R1 code", code, 0);
    chk("R1 cr", cr, m_cr);
    chk("R1 fprf", fprf, m_fprf);
    chk("R1 flags", {vx_snan, vx_cmp, fx}, 0);
    rst_n = 1;
  endtask

  function automatic logic [3:0] ref_code(input logic [63:0] a, input logic [63:0] b);
    real ra, rb;
    if ((a[62:52] == 11'h7FF && a[51:0] != 0) || (b[62:52] == 11'h7FF && b[51:0] != 0))
      return 4'b0001;
    ra = $bitstoreal(a); rb = $bitstoreal(b);
    if (ra < rb) return 4'b1000;
    if (ra > rb) return 4'b0100;
    return 4'b0010;
  endfunction

  // driver: one compare, expectation pushed to the scoreboard
  task automatic cmp(input string tag, input logic ord, input logic en, input int sel,
                     input logic [63:0] a, input logic [63:0] b);
    exp_t e;
    logic sa, sb, qa, qb, rs, rc;
    @(negedge clk);
    ordered = ord; inv_en = en; field_sel = 3'(sel); op_a = a; op_b = b; start = 1;
    sa = a[62:52] == 11'h7FF && a[51:0] != 0 && !a[51];
    sb = b[62:52] == 11'h7FF && b[51:0] != 0 && !b[51];
    qa = a[62:52] == 11'h7FF && a[51];
    qb = b[62:52] == 11'h7FF && b[51];
    rs = sa || sb;
    rc = ord && (rs ? !en : (qa || qb));
    m_code = ref_code(a, b);
    m_fprf = {m_fprf[4], m_code};
    m_cr[31 - 4*sel -: 4] = m_code;
    m_snan |= rs; m_cmp |= rc; m_fx |= rs | rc;
    e.code = m_code; e.fprf = m_fprf; e.cr = m_cr;
    e.snan = m_snan; e.cmp = m_cmp; e.fx = m_fx; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    start = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 done without start actual=1 expected=0");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " code"}, code, e.code);
        chk("R9 fprf", fprf, e.fprf);
        chk("R10 cr", cr, e.cr);
        chk({e.tag, " vx_snan"}, vx_snan, e.snan);
        chk({e.tag, " vx_cmp"}, vx_cmp, e.cmp);
        chk("R8 fx", fx, e.fx);
      end
    end
  end

  localparam logic [63:0] ONE = 64'h3FF0000000000000, TWO = 64'h4000000000000000;
  localparam logic [63:0] THREE = 64'h4008000000000000, MONE = 64'hBFF0000000000000;
  localparam logic [63:0] PZ = 64'h0, NZ = 64'h8000000000000000;
  localparam logic [63:0] NINF = 64'hFFF0000000000000, PINF = 64'h7FF0000000000000;
  localparam logic [63:0] MFIVE = 64'hC014000000000000, MTWO = 64'hC000000000000000;
  localparam logic [63:0] MTHREE = 64'hC008000000000000, MAXF = 64'h7FEFFFFFFFFFFFFF;
  localparam logic [63:0] QNAN = 64'h7FF8000000000000, SNAN = 64'h7FF0000000000001;
  localparam logic [63:0] NSNAN = 64'hFFF4000000000000, TINY = 64'h0000000000000001;

  initial begin
    int cyc = 0;
    fork
      begin
        do_reset();
        // flag cases first while all sticky flags are clear
        cmp("R6 unordered quiet", 0, 0, 2, QNAN, ONE);
        cmp("R5 unordered snan", 0, 0, 3, ONE, SNAN);
        cmp("R7 ordered snan en=1", 1, 1, 4, NSNAN, TWO);
        cmp("R6 ordered quiet", 1, 1, 5, TWO, QNAN);
        cmp("R3 lt", 0, 0, 0, ONE, TWO);
        cmp("R3 gt", 1, 0, 1, THREE, MONE);
        cmp("R4 signed zero", 0, 0, 6, PZ, NZ);
        cmp("R4 -inf", 1, 0, 7, NINF, MFIVE);
        cmp("R4 negatives", 0, 0, 0, MTWO, MTHREE);
        cmp("R4 inf vs max", 1, 0, 2, PINF, MAXF);
        cmp("R4 subnormal", 0, 0, 3, TINY, NZ);
        cmp("R3 equal", 0, 0, 1, MFIVE, MFIVE);
        // R11: idle cycles leave state unchanged
        repeat (4) @(negedge clk);
        chk("R11 idle cr", cr, m_cr);
        chk("R11 idle fprf", fprf, m_fprf);
        chk("R11 idle code", code, m_code);
        chk("R11 idle flags", {vx_snan, vx_cmp, fx}, {m_snan, m_cmp, m_fx});
        // R7 with enable clear, from fresh flags
        do_reset();
        cmp("R7 ordered snan en=0", 1, 0, 4, SNAN, SNAN);
        cmp("R3 back-to-back", 0, 0, 5, MONE, ONE);
        repeat (3) @(negedge clk);
        chk("R2 queue drained", q.size(), 0);
      end
      begin
        while (cyc < 100000) begin @(posedge clk); cyc++; end
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule